// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table in memory. A request carries the virtual address, a write flag and the base address of the top-level table for the running address space. The base is sampled with each request, so a context switch only needs a new value on that input. The walker reads one top-level (directory) entry and one leaf entry through a simple memory port with a request pulse and an acknowledge. It then returns either the physical address or a fault with a cause code.

The virtual address splits into three fields. Bits [31:22] index the directory, bits [21:12] index the leaf table, and bits [11:0] are the byte offset inside a 4 KiB page. Each entry is 32 bits wide and is fetched from its table base plus four times its index. Entry bits are used as follows:
- bit 0: present
- bit 1: writable
- bit 2: used
- bit 3: modified
- bits [31:12]: frame number (in a leaf entry) or the 4 KiB-aligned base of the leaf table (in a directory entry)

On a successful access the walker stores the leaf entry back with its used bit set, and also its modified bit for a write. It skips that store when the bits already hold those values.

Only one walk runs at a time. `busy` is high from the accepting edge until the edge that raises the one-cycle `done` pulse. The response outputs hold their values until the next `done`.

Top module: `pt_walker`

## Requirements
- R1: A request is accepted only when `busy` is low. The first memory access is a read (`mem_we`=0) at `root_base + 4*vaddr[31:22]`, using the base sampled with the request.
- R2: When the directory entry has bit 0 set, the second access is a read at `{dir_entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R3: When the leaf entry is present and the access is permitted, `done` comes with `resp_fault`=0, `resp_cause`=2'b00 and `resp_paddr = {leaf[31:12], vaddr[11:0]}`.
- R4: A directory entry with bit 0 clear ends the walk. The response is `resp_fault`=1, `resp_cause`=2'b01 and `resp_paddr`=0, with no further memory access.
- R5: A leaf entry with bit 0 clear ends the walk with `resp_cause`=2'b01, `resp_paddr`=0 and no write-back.
- R6: A write to a present leaf with bit 1 clear ends the walk with `resp_fault`=1, `resp_cause`=2'b10, `resp_paddr`=0 and no write-back.
- R7: A successful read whose leaf has bit 2 clear is followed by one write (`mem_we`=1) to the leaf address. The written data is the leaf entry with bit 2 set and every other bit unchanged.
- R8: A successful write whose leaf lacks bit 2 or bit 3 is followed by one write to the leaf address. The written data is the leaf with both bits set and every other bit unchanged.
- R9: No write-back is issued when the leaf already has bit 2 set (read), or both bit 2 and bit 3 set (write).
- R10: Each memory request is a one-cycle `mem_req` pulse. The walker waits for `mem_ack`, with `mem_rdata` valid in that cycle, before the next step. `busy` drops in the cycle `done` pulses. A `req_valid` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when busy is low |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| root_base | input | 32 | Byte address of the directory for the current address space |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: response outputs are valid |
| resp_fault | output | 1 | The walk ended in a fault |
| resp_cause | output | 2 | 00 none, 01 not present, 10 write to read-only page |
| resp_paddr | output | 32 | Physical address, zero on a fault |
| mem_req | output | 1 | One-cycle memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated leaf entry for a write |
| mem_ack | input | 1 | Memory has completed the outstanding request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The bench targets several corner cases, each with a typical wrong behaviour it would expose:
- Directory entry not present, but with a nonzero frame field: a walker that ignores bit 0 would issue a second read.
- Read-only leaf, written and then read: a walker that mixes up the checks would mark a faulting write as used or dirty, or would refuse the legal read.
- Leaf that already carries the used and modified bits: a walker that always writes back, or never does, shows up as an extra or missing write on the memory port.
- Second root table: a walker that keeps a stale base reads the wrong directory.
- Request raised in the middle of a walk: it must not disturb the access sequence, and must not start a second walk.

Memory latency varies from walk to walk, so a walker that acts on a stale `mem_rdata` gets caught.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // Bit positions inside a table entry
  localparam int PTE_PRESENT  = 0;
  localparam int PTE_WRITABLE = 1;
  localparam int PTE_USED     = 2;
  localparam int PTE_DIRTY    = 3;

  // log2 of the entry size in bytes
  localparam int ENTRY_SHIFT  = 2;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2
  } flt_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_DIR,
    WS_LEAF,
    WS_WB
  } wstate_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic [AW-1:0]       root,
  input  logic [IDX_W-1:0]    dir_idx,
  input  logic [AW-OFF_W-1:0] dir_frame,
  input  logic [IDX_W-1:0]    leaf_idx,
  output logic [AW-1:0]       dir_addr,
  output logic [AW-1:0]       leaf_addr
);
  localparam int SCALED_W = IDX_W + ENTRY_SHIFT;

  logic [SCALED_W-1:0] dir_ofs;
  logic [SCALED_W-1:0] leaf_ofs;

  assign dir_ofs   = {dir_idx,  {ENTRY_SHIFT{1'b0}}};
  assign leaf_ofs  = {leaf_idx, {ENTRY_SHIFT{1'b0}}};

  assign dir_addr  = root + AW'(dir_ofs);
  assign leaf_addr = {dir_frame, {OFF_W{1'b0}}} + AW'(leaf_ofs);
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input  logic [AW-1:0]    leaf,
  input  logic             is_write,
  input  logic [OFF_W-1:0] off,
  output flt_e             cause,
  output logic             need_wb,
  output logic [AW-1:0]    new_leaf,
  output logic [AW-1:0]    paddr
);
  always_comb begin
    new_leaf           = leaf;
    new_leaf[PTE_USED] = 1'b1;
    if (is_write) new_leaf[PTE_DIRTY] = 1'b1;

    if (!leaf[PTE_PRESENT])                 cause = FLT_ABSENT;
    else if (is_write && !leaf[PTE_WRITABLE]) cause = FLT_PROT;
    else                                    cause = FLT_NONE;

    need_wb = (cause == FLT_NONE) && (new_leaf != leaf);
    paddr   = {leaf[AW-1:OFF_W], off};
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter  int IDX_W = 10,
  parameter  int OFF_W = 12,
  localparam int AW    = 2 * IDX_W + OFF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_write,
  input  logic [AW-1:0] root_base,
  output logic          busy,
  output logic          done,
  output logic          resp_fault,
  output logic [1:0]    resp_cause,
  output logic [AW-1:0] resp_paddr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata
);
  localparam int DIR_LSB  = AW - IDX_W;
  localparam int LEAF_LSB = OFF_W;

  wstate_e       state;
  logic [AW-1:0] vaddr_q;
  logic          write_q;
  logic [AW-1:0] pa_q;

  logic [AW-1:0] dir_addr, leaf_addr;
  flt_e          leaf_cause;
  logic          leaf_wb;
  logic [AW-1:0] leaf_new, leaf_pa;

  logic          ack_ok;
  logic          fin;
  flt_e          fin_cause;
  logic [AW-1:0] fin_pa;

  ptw_addr_gen #(.AW(AW), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .root      (root_base),
    .dir_idx   (req_vaddr[DIR_LSB +: IDX_W]),
    .dir_frame (mem_rdata[AW-1:OFF_W]),
    .leaf_idx  (vaddr_q[LEAF_LSB +: IDX_W]),
    .dir_addr  (dir_addr),
    .leaf_addr (leaf_addr)
  );

  ptw_leaf_eval #(.AW(AW), .OFF_W(OFF_W)) u_eval (
    .leaf     (mem_rdata),
    .is_write (write_q),
    .off      (vaddr_q[OFF_W-1:0]),
    .cause    (leaf_cause),
    .need_wb  (leaf_wb),
    .new_leaf (leaf_new),
    .paddr    (leaf_pa)
  );

  // An acknowledge counts only once the request pulse is over
  assign ack_ok = mem_ack && !mem_req;

  always_comb begin
    fin       = 1'b0;
    fin_cause = FLT_NONE;
    fin_pa    = '0;
    if (ack_ok) begin
      case (state)
        WS_DIR: begin
          if (!mem_rdata[PTE_PRESENT]) begin
            fin       = 1'b1;
            fin_cause = FLT_ABSENT;
          end
        end
        WS_LEAF: begin
          if (leaf_cause != FLT_NONE) begin
            fin       = 1'b1;
            fin_cause = leaf_cause;
          end else if (!leaf_wb) begin
            fin    = 1'b1;
            fin_pa = leaf_pa;
          end
        end
        WS_WB: begin
          fin    = 1'b1;
          fin_pa = pa_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= WS_IDLE;
      vaddr_q    <= '0;
      write_q    <= 1'b0;
      pa_q       <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      resp_fault <= 1'b0;
      resp_cause <= 2'b00;
      resp_paddr <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      if (fin) begin
        done       <= 1'b1;
        busy       <= 1'b0;
        resp_fault <= (fin_cause != FLT_NONE);
        resp_cause <= fin_cause;
        resp_paddr <= fin_pa;
        mem_we     <= 1'b0;
        state      <= WS_IDLE;
      end else begin
        case (state)
          WS_IDLE: begin
            if (req_valid) begin
              vaddr_q  <= req_vaddr;
              write_q  <= req_write;
              busy     <= 1'b1;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= dir_addr;
              state    <= WS_DIR;
            end
          end
          WS_DIR: begin
            if (ack_ok) begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= leaf_addr;
              state    <= WS_LEAF;
            end
          end
          WS_LEAF: begin
            if (ack_ok) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_wdata <= leaf_new;
              pa_q      <= leaf_pa;
              state     <= WS_WB;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          resp_fault,
  input logic [1:0]    resp_cause,
  input logic [AW-1:0] resp_paddr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata
);
  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R10
  req_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R4
  fault_code_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (resp_fault == (resp_cause != 2'b00)));

  // R4
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
    (done && resp_fault) |-> (resp_paddr == '0));

  // R7
  wb_used_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[2] && mem_wdata[0]));

  // R7
  wb_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> $stable(mem_addr));
endmodule

bind pt_walker pt_walker_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .resp_fault (resp_fault),
  .resp_cause (resp_cause),
  .resp_paddr (resp_paddr),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [31:0] root_base = '0;
  logic        busy, done, resp_fault;
  logic [1:0]  resp_cause;
  logic [31:0] resp_paddr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .root_base(root_base), .busy(busy), .done(done),
    .resp_fault(resp_fault), .resp_cause(resp_cause), .resp_paddr(resp_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Sparse memory model and expected access stream
  logic [31:0] mem [logic [31:0]];
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  bit          q_we[$];
  string       q_tag[$];
  int          lat = 0;
  bit          pend = 0;
  int          wait_n = 0;
  logic [31:0] p_addr;
  bit          p_we;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (pend) begin
      if (wait_n == 0) begin
        mem_ack = 1'b1;
        if (!p_we) mem_rdata = rd(p_addr);
        pend = 0;
      end else wait_n--;
    end
    if (!rst && mem_req) begin
      if (q_addr.size() == 0) begin
        check(0, "R10", "unexpected memory request", mem_addr, 32'h0);
      end else begin
        logic [31:0] ea, ed;
        bit ew;
        string et;
        ea = q_addr.pop_front(); ed = q_data.pop_front();
        ew = q_we.pop_front();   et = q_tag.pop_front();
        check(mem_addr == ea, et, "access address", mem_addr, ea);
        check(mem_we == ew, et, "access direction", 32'(mem_we), 32'(ew));
        if (ew) check(mem_wdata == ed, et, "write-back data", mem_wdata, ed);
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
      pend = 1; wait_n = lat; p_addr = mem_addr; p_we = mem_we;
    end
  end

  function automatic logic [31:0] va(input int i1, input int i2, input int off);
    return {i1[9:0], i2[9:0], off[11:0]};
  endfunction

  task automatic walk(input logic [31:0] v, input bit wr, input logic [31:0] root,
                      input int l, input string tag, input bit poke);
    logic [31:0] a1, e1, a2, e2, nw, exp_pa;
    logic [1:0]  exp_cause;
    int n;
    a1 = root + {20'h0, v[31:22], 2'b00};
    e1 = rd(a1);
    q_addr.push_back(a1); q_data.push_back(0); q_we.push_back(0); q_tag.push_back("R1");
    exp_pa = 0;
    if (!e1[0]) exp_cause = 2'b01;
    else begin
      a2 = {e1[31:12], 12'h0} + {20'h0, v[21:12], 2'b00};
      e2 = rd(a2);
      q_addr.push_back(a2); q_data.push_back(0); q_we.push_back(0); q_tag.push_back("R2");
      if (!e2[0]) exp_cause = 2'b01;
      else if (wr && !e2[1]) exp_cause = 2'b10;
      else begin
        exp_cause = 2'b00;
        exp_pa = {e2[31:12], v[11:0]};
        nw = e2 | 32'h4 | (wr ? 32'h8 : 32'h0);
        if (nw != e2) begin
          q_addr.push_back(a2); q_data.push_back(nw); q_we.push_back(1);
          q_tag.push_back(wr ? "R8" : "R7");
        end
      end
    end
    lat = l;
    @(negedge clk);
    req_vaddr = v; req_write = wr; root_base = root; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 500) begin
      check(busy == 1'b1, "R10", {tag, " busy during walk"}, 32'(busy), 32'h1);
      if (poke && n == 1) begin
        req_valid = 1'b1; req_vaddr = 32'hFFC0_0000; req_write = 1'b1;
      end else req_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    check(done == 1'b1, "R10", {tag, " walk finished"}, 32'(done), 32'h1);
    check(busy == 1'b0, "R10", {tag, " busy with done"}, 32'(busy), 32'h0);
    check(resp_fault == (exp_cause != 0), tag, "fault flag", 32'(resp_fault),
          32'(exp_cause != 0));
    check(resp_cause == exp_cause, tag, "cause", 32'(resp_cause), 32'(exp_cause));
    check(resp_paddr == exp_pa, tag, "physical address", resp_paddr, exp_pa);
    check(q_addr.size() == 0, tag, "missing memory accesses", q_addr.size(), 0);
    q_addr.delete(); q_data.delete(); q_we.delete(); q_tag.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // Directory for address space A at 0x10000, B at 0x30000
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0001_0008] = 32'h0004_0000;  // not present, nonzero frame
    mem[32'h0002_0014] = 32'hABCD_E003;  // present, writable
    mem[32'h0002_0018] = 32'h1234_5001;  // present, read-only
    mem[32'h0002_001C] = 32'h5555_5006;  // not present
    mem[32'h0002_0020] = 32'h6789_A00F;  // all bits set
    mem[32'h0003_0004] = 32'h0005_0001;
    mem[32'h0005_0014] = 32'h0BEE_F001;

    repeat (3) @(negedge clk);
    check(busy == 0, "R10", "reset busy", 32'(busy), 0);
    check(done == 0, "R10", "reset done", 32'(done), 0);
    check(mem_req == 0, "R10", "reset mem_req", 32'(mem_req), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0, "R10", "idle busy", 32'(busy), 0);

    walk(va(1, 5, 12'h123), 0, 32'h0001_0000, 0, "R3 R7", 0);
    walk(va(1, 5, 12'hFFF), 0, 32'h0001_0000, 2, "R9 read", 0);
    walk(va(1, 5, 12'h000), 1, 32'h0001_0000, 1, "R8", 0);
    walk(va(1, 5, 12'h800), 1, 32'h0001_0000, 0, "R9 write", 0);
    walk(va(1, 6, 12'h010), 1, 32'h0001_0000, 1, "R6", 0);
    walk(va(1, 6, 12'h010), 0, 32'h0001_0000, 0, "R7 read-only", 0);
    walk(va(1, 7, 12'h000), 0, 32'h0001_0000, 1, "R5", 0);
    walk(va(2, 5, 12'h000), 0, 32'h0001_0000, 3, "R4", 0);
    walk(va(1, 5, 12'h456), 0, 32'h0003_0000, 0, "R1 R2 new root", 0);
    walk(va(1, 8, 12'h321), 1, 32'h0001_0000, 2, "R10 ignored request", 1);

    repeat (6) @(negedge clk);
    check(busy == 0, "R10", "no walk after ignored request", 32'(busy), 0);
    check(mem[32'h0002_0014] == 32'hABCD_E00F, "R8", "final leaf state",
          mem[32'h0002_0014], 32'hABCD_E00F);
    check(mem[32'h0002_0018] == 32'h1234_5005, "R6", "read-only leaf state",
          mem[32'h0002_0018], 32'h1234_5005);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule